// File: doc/BRIEF.md
# Instruction Count Debug Trigger

This block is one debug trigger that counts retired instructions and asks for a breakpoint when a programmed budget of instructions runs out. Software programs it by writing a control word. The word holds a 14-bit remaining count and a set of per-privilege enable bits. The enable bits are split into one group for non-virtualized execution and one group for virtualized execution.

The core sends one retire pulse per instruction, together with its current privilege level and a virtualization flag. While the count is non-zero and the current mode is enabled, each retire pulse lowers the count by one. Retires in a disabled mode leave the count untouched, so counting pauses and later resumes. When the count reaches zero, a one-cycle breakpoint request is raised. The trigger then stays idle until it is written again. The control word can be read back at any time and carries the live remaining count.

Top module: `icnt_trigger`

## Requirements
- R1: `ctrl_o[23:10]` and `count_o` both show the live remaining count, which is updated on the clock edge after each decrement or write.
- R2: While the count is zero, a retire pulse does not change the count and does not raise `bp_req_o`.
- R3: The enable bits are taken from the written control word as follows. When `virt_i`=0, bit 6 enables privilege 0 (U), bit 7 enables privilege 1 (S) and bit 9 enables privilege 3 (M); privilege 2 is never enabled. When `virt_i`=1, bit 25 enables privilege 0 (VU) and bit 26 enables privilege 1 (VS); privileges 2 and 3 are never enabled.
- R4: A retire pulse in a mode whose enable bit is clear leaves the count unchanged, and counting resumes once an enabled mode returns.
- R5: A retire pulse in an enabled mode with a non-zero count lowers the count by exactly one.
- R6: The retire pulse that takes the count from 1 to 0 sets `bp_req_o` high for exactly the one cycle after that edge.
- R7: In `ctrl_o`, bits 31:28 always read 4'd3 (the instruction-count type code). Bits 27, 24, 8 and 5:0 always read zero (the action, hit and pending positions), whatever was written to them.
- R8: When `ctrl_we_i` is high, the count is loaded from `ctrl_wdata_i[23:10]` and the enables are loaded too. This overrides any decrement and any breakpoint request in that same cycle.
- R9: After firing, the count stays zero and no further request is raised until the trigger is rewritten.
- R10: After reset the count is zero, all enables are clear and `bp_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| retire_i | input | 1 | One pulse per retired instruction |
| priv_i | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Core is running virtualized |
| ctrl_o | output | 32 | Control word readback with live count |
| count_o | output | 14 | Live remaining count |
| bp_req_o | output | 1 | One-cycle breakpoint request |

## Verification
The assertions assume a single retire pulse per cycle and a privilege input that is stable while the pulse is sampled. They make no assumption about how a write and a retire line up. The stimulus drives every input at the falling edge and holds it for a full cycle. It sweeps all 32 enable patterns against every privilege and virtualization combination, and it sets up the collision of a write with a final decrement on purpose.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned CNT_W     = 14;
  localparam int unsigned CNT_LSB   = 10;
  localparam int unsigned EN_LSB    = 6;
  localparam int unsigned VEN_LSB   = 25;
  localparam int unsigned TYPE_LSB  = 28;
  localparam int unsigned TYPE_W    = 4;
  localparam logic [3:0]  TYPE_CODE = 4'd3;
  localparam int unsigned NPRIV     = 4;
  localparam int unsigned NVPRIV    = 2;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/icnt_ctrl_reg.sv
module icnt_ctrl_reg
  import icnt_pkg::*;
#(
  parameter int unsigned NP = NPRIV,
  parameter int unsigned NV = NVPRIV
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [NP-1:0] host_wen_i,
  input  logic [NV-1:0] virt_wen_i,
  output logic [NP-1:0] host_en_o,
  output logic [NV-1:0] virt_en_o
);
  // privilege 2 is reserved: no storage, reads zero
  for (genvar i = 0; i < NP; i++) begin : g_host
    if (i == int'(PRIV_RSV)) begin : g_rsv
      assign host_en_o[i] = 1'b0;
      logic rsv_unused;
      assign rsv_unused = host_wen_i[i];
    end else begin : g_bit
      logic en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   en_q <= 1'b0;
        else if (we_i) en_q <= host_wen_i[i];
      end
      assign host_en_o[i] = en_q;
    end
  end

  for (genvar j = 0; j < NV; j++) begin : g_virt
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q <= 1'b0;
      else if (we_i) en_q <= virt_wen_i[j];
    end
    assign virt_en_o[j] = en_q;
  end

  a_r10_en_reset: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (host_en_o == '0 && virt_en_o == '0));
endmodule

// File: rtl/icnt_priv_gate.sv
module icnt_priv_gate
  import icnt_pkg::*;
#(
  parameter int unsigned NP = NPRIV,
  parameter int unsigned NV = NVPRIV
) (
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic [NP-1:0] host_en_i,
  input  logic [NV-1:0] virt_en_i,
  output logic          active_o
);
  always_comb begin
    if (virt_i) active_o = !priv_i[1] && virt_en_i[priv_i[0]];
    else        active_o = host_en_i[priv_i];
  end

  // R3: virtualized M or reserved level never counts
  always_comb begin
    if (virt_i && priv_i[1])
      a_r3_virt_high: assert (!active_o);
  end
endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
  parameter int unsigned CW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          retire_i,
  input  logic          active_i,
  output logic [CW-1:0] count_o,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fire_q, fire_d;
  logic          step;

  assign step = retire_i && active_i && (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (step) begin
      cnt_d  = cnt_q - 1'b1;
      fire_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign count_o = cnt_q;
  assign fire_o  = fire_q;

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(load_val_i) && !fire_o));
  a_r5_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && retire_i && active_i && count_o != '0) |=> count_o == $past(count_o) - 1'b1);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(retire_i && active_i)) |=> ($stable(count_o) && !fire_o));
  a_r2_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && count_o == '0) |=> (count_o == '0 && !fire_o));
  a_r6_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
  a_r6_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> count_o == '0);
endmodule

// File: rtl/icnt_trigger.sv
module icnt_trigger
  import icnt_pkg::*;
#(
  parameter int unsigned CNT_WIDTH = CNT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ctrl_we_i,
  input  logic [XLEN-1:0] ctrl_wdata_i,
  input  logic            retire_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  output logic [XLEN-1:0] ctrl_o,
  output logic [CNT_WIDTH-1:0] count_o,
  output logic            bp_req_o
);
  localparam int unsigned CNT_MSB = CNT_LSB + CNT_WIDTH - 1;

  logic [NPRIV-1:0]     host_en;
  logic [NVPRIV-1:0]    virt_en;
  logic                 active;
  logic [CNT_WIDTH-1:0] cnt;

  icnt_ctrl_reg #(.NP(NPRIV), .NV(NVPRIV)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .host_wen_i (ctrl_wdata_i[EN_LSB +: NPRIV]),
    .virt_wen_i (ctrl_wdata_i[VEN_LSB +: NVPRIV]),
    .host_en_o  (host_en),
    .virt_en_o  (virt_en)
  );

  icnt_priv_gate #(.NP(NPRIV), .NV(NVPRIV)) u_gate (
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .host_en_i (host_en),
    .virt_en_i (virt_en),
    .active_o  (active)
  );

  icnt_counter #(.CW(CNT_WIDTH)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctrl_we_i),
    .load_val_i (ctrl_wdata_i[CNT_MSB:CNT_LSB]),
    .retire_i   (retire_i),
    .active_i   (active),
    .count_o    (cnt),
    .fire_o     (bp_req_o)
  );

  // action, hit, pending, mode and type bits of the write are dropped
  logic wdata_unused;
  assign wdata_unused = ^{ctrl_wdata_i[XLEN-1:VEN_LSB+NVPRIV],
                          ctrl_wdata_i[VEN_LSB-1:CNT_MSB+1],
                          ctrl_wdata_i[EN_LSB-1:0]};

  always_comb begin
    ctrl_o = '0;
    ctrl_o[TYPE_LSB +: TYPE_W]   = TYPE_CODE;
    ctrl_o[VEN_LSB +: NVPRIV]    = virt_en;
    ctrl_o[CNT_MSB:CNT_LSB]      = cnt;
    ctrl_o[EN_LSB + 0]           = host_en[0];
    ctrl_o[EN_LSB + 1]           = host_en[1];
    ctrl_o[EN_LSB + 3]           = host_en[3];
  end

  assign count_o = cnt;

  a_r7_zero_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[5:0] == '0 && !ctrl_o[8] && !ctrl_o[24] && !ctrl_o[27]));
  a_r1_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> ctrl_o[CNT_MSB:CNT_LSB] == $past(ctrl_wdata_i[CNT_MSB:CNT_LSB]));
endmodule

// File: tb/icnt_trigger_bench.sv
module icnt_trigger_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        retire = 1'b0;
  logic [1:0]  priv = 2'd3;
  logic        virt = 1'b0;
  logic [31:0] ctrl_rd;
  logic [13:0] count;
  logic        bp;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  icnt_trigger u_icnt_trigger (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .retire_i(retire), .priv_i(priv), .virt_i(virt),
    .ctrl_o(ctrl_rd), .count_o(count), .bp_req_o(bp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // e: {VS,VU,M,S,U}
  function automatic logic [31:0] mkctrl(input logic [4:0] e, input logic [13:0] c);
    logic [31:0] w = '0;
    w[6] = e[0]; w[7] = e[1]; w[9] = e[2]; w[25] = e[3]; w[26] = e[4];
    w[23:10] = c;
    return w;
  endfunction

  // one full cycle, entered and left at a falling edge
  task automatic cyc(input logic w, input logic [31:0] d, input logic r,
                     input logic [1:0] p, input logic v);
    we = w; wdata = d; retire = r; priv = p; virt = v;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; retire = 1'b0;
  endtask

  function automatic logic en_exp(input logic [4:0] e, input logic [1:0] p, input logic v);
    if (v) return (p == 2'd0) ? e[3] : (p == 2'd1) ? e[4] : 1'b0;
    case (p)
      2'd0: return e[0];
      2'd1: return e[1];
      2'd3: return e[2];
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 count", 32'(count), 0);
    chk("R10 bp", 32'(bp), 0);
    chk("R10 ctrl", ctrl_rd, 32'h3000_0000);

    // R3 R4 R5 sweep: all enables x privilege x virt
    for (int e = 0; e < 32; e++)
      for (int p = 0; p < 4; p++)
        for (int v = 0; v < 2; v++) begin
          cyc(1'b1, mkctrl(5'(e), 14'd3), 1'b0, 2'(p), 1'(v));
          cyc(1'b0, '0, 1'b1, 2'(p), 1'(v));
          chk("R3 R4 R5 gated count", 32'(count),
              en_exp(5'(e), 2'(p), 1'(v)) ? 32'd2 : 32'd3);
        end

    // R1 R7 readback with all bits written
    cyc(1'b1, 32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0);
    chk("R1 R7 readback", ctrl_rd, 32'h36FF_FEC0);
    chk("R1 max count", 32'(count), 32'h3FFF);
    cyc(1'b1, 32'h0000_0000, 1'b0, 2'd3, 1'b0);
    chk("R7 cleared", ctrl_rd, 32'h3000_0000);

    // R5 R6 countdown from 5 in M
    cyc(1'b1, mkctrl(5'b00100, 14'd5), 1'b0, 2'd3, 1'b0);
    for (int i = 4; i >= 1; i--) begin
      cyc(1'b0, '0, 1'b1, 2'd3, 1'b0);
      chk("R5 countdown", 32'(count), 32'(i));
      chk("R6 no early bp", 32'(bp), 0);
    end
    cyc(1'b0, '0, 1'b1, 2'd3, 1'b0);
    chk("R6 reach zero", 32'(count), 0);
    chk("R6 bp high", 32'(bp), 1);
    chk("R1 readback zero", 32'(ctrl_rd[23:10]), 0);
    cyc(1'b0, '0, 1'b0, 2'd3, 1'b0);
    chk("R6 bp one cycle", 32'(bp), 0);
    // R9 stays idle after firing
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, '0, 1'b1, 2'd3, 1'b0);
      chk("R9 idle count", 32'(count), 0);
      chk("R9 no refire", 32'(bp), 0);
    end

    // R2 programmed zero never fires
    cyc(1'b1, mkctrl(5'b11111, 14'd0), 1'b0, 2'd0, 1'b0);
    cyc(1'b0, '0, 1'b1, 2'd0, 1'b0);
    chk("R2 zero count", 32'(count), 0);
    chk("R2 zero no bp", 32'(bp), 0);

    // R4 pause and resume
    cyc(1'b1, mkctrl(5'b00100, 14'd4), 1'b0, 2'd3, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, 2'd0, 1'b0);
    chk("R4 paused", 32'(count), 4);
    cyc(1'b0, '0, 1'b1, 2'd3, 1'b1);
    chk("R4 paused virt M", 32'(count), 4);
    cyc(1'b0, '0, 1'b1, 2'd3, 1'b0);
    chk("R4 resumed", 32'(count), 3);

    // R8 write overrides final decrement
    cyc(1'b1, mkctrl(5'b00100, 14'd1), 1'b0, 2'd3, 1'b0);
    cyc(1'b1, mkctrl(5'b00100, 14'd7), 1'b1, 2'd3, 1'b0);
    chk("R8 load wins", 32'(count), 7);
    chk("R8 no bp", 32'(bp), 0);

    // R6 in virtualized VS
    cyc(1'b1, mkctrl(5'b10000, 14'd1), 1'b0, 2'd1, 1'b1);
    cyc(1'b0, '0, 1'b1, 2'd1, 1'b1);
    chk("R6 virt fire", 32'(bp), 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule